// File: doc/BRIEF.md
# MDIO Management Master

This block drives clause 22 management frames toward one or more PHYs. It has a small register window with two words. Software writes the command word, which carries the opcode, the PHY address, the register address, 16 bits of write data and a start bit called GO. The block then shifts out one whole management frame on MDC and MDIO. While the frame runs, GO reads back as 1. The block clears GO when the frame is over, so software learns of completion by polling GO.

A read frame puts its result in the status word. That word holds the 16 data bits sampled from the PHY and an error flag. The flag is set when the turnaround bit after the address fields is not pulled low, which is the case when no PHY answers at that address. The PHY address field is a full five bits wide, so software can find a PHY by scanning all 32 addresses and reading an identifier register at each one.

MDC comes from the system clock through a parameterised divider and stays low when no frame is in progress. MDIO leaves the block as an output, an output enable and an input. The output changes only when MDC falls. The input is sampled when MDC rises.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word and the command word read 0, and MDC, MDIO output enable and GO are all 0. While idle, MDIO output is 1.
- R2: A write to byte offset 0x4 with bit 31 set launches a frame. Bit 31 reads 1 until the frame ends and 0 afterwards. A frame has exactly 64 MDC rising edges.
- R3: Every frame begins with 32 bits of 1, followed by the start pattern 0 then 1.
- R4: Command bit 26 set selects a write. The frame then carries opcode 0,1, then PHY address bits 25:21 and register address bits 20:16, each MSB first. Turnaround is driven as 1,0, then data bits 15:0 are sent MSB first. The output enable stays high for all 64 bits.
- R5: Command bit 26 clear selects a read, with opcode 1,0. The output enable goes low for the two turnaround bits and the 16 data bits. After completion, status bits 15:0 at offset 0x0 hold the 16 bits sampled on MDC rising edges, MSB first.
- R6: Status bit 31 is set after a read whose second turnaround bit sampled 1. Status bit 31 is cleared after a read whose second turnaround bit sampled 0. Status bits 30:16 read 0.
- R7: A write to offset 0x4 while GO is 1 has no effect. The command fields read back unchanged and no further frame starts. This includes a write that lands in the very cycle in which the frame ends.
- R8: While a frame runs, MDC stays high for CLK_DIV clock cycles and low for CLK_DIV clock cycles. MDIO output changes only in the cycle where MDC falls.
- R9: A write frame leaves the status word unchanged.
- R10: All 32 PHY addresses 0 to 31 can be targeted. A scan reads back valid data only from the address where a PHY responds.
- R11: A write to offset 0x4 with bit 31 clear while idle updates the command fields and starts no frame. Writes to offset 0x0 have no effect. Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte offset within the register window |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable, 1 while the master drives the line |
| mdioIn | input | 1 | MDIO line value as seen at the pin |

## Verification
Two events can fall in the same clock cycle: the end of a frame, where GO clears and the status word is loaded, and a software write to the command word. The bench counts the exact number of cycles from the launch edge and places a write with GO set on the cycle where the last MDC fall happens. It then expects GO to read 0, the command fields to match the finished command, and no new MDC activity. A second write made one cycle later must be accepted, so the cycle boundary between the two outcomes is checked on both sides.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W    = 32;
  localparam int OFS_STAT = 0;
  localparam int OFS_CMD  = 4;
  localparam int GO_BIT   = 31;
  localparam int OP_BIT   = 26;
  localparam int PA_LSB   = 21;
  localparam int RA_LSB   = 16;
  localparam int ERR_BIT  = 31;
  localparam int FLD_W    = 5;
  localparam int DAT_W    = 16;

  typedef struct packed {
    logic loadFrame;
    logic shiftBit;
    logic sampleTa;
    logic sampleData;
    logic finish;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         launch,
  input  logic         isRead,
  output logic         busy,
  output logic         mdc,
  output logic         mdioOe,
  output mdioStrobes_t st
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = $clog2(CLK_DIV + 1);
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int TA2_IDX   = PRE_LEN + 15;
  localparam int DATA_IDX  = PRE_LEN + 16;
  localparam int LAST_IDX  = FRAME_LEN - 1;

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic tick, riseEv, fallEv, lastBit;

  assign tick    = busy && (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseEv  = tick && !mdc;
  assign fallEv  = tick && mdc;
  assign lastBit = (bitCnt == CNT_W'(LAST_IDX));

  always_comb begin
    st            = '0;
    st.loadFrame  = launch && !busy;
    st.shiftBit   = fallEv;
    st.sampleTa   = riseEv && (bitCnt == CNT_W'(TA2_IDX));
    st.sampleData = riseEv && (bitCnt >= CNT_W'(DATA_IDX));
    st.finish     = fallEv && lastBit;
  end

  assign mdioOe = busy && !(isRead && (bitCnt >= CNT_W'(TA_IDX)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (st.loadFrame) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (fallEv) begin
          if (lastBit) busy <= 1'b0;
          else         bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              busy,
  input  mdioStrobes_t      st,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              launch,
  output logic              isRead,
  output logic [REG_W-1:0]  statusWord,
  output logic [REG_W-1:0]  cmdWord
);
  localparam int FRAME_LEN = PRE_LEN + 32;

  logic             cmdWr;
  logic             wOp;
  logic [FLD_W-1:0] wPa, wRa;
  logic [DAT_W-1:0] wDat;

  logic             cmdOp;
  logic [FLD_W-1:0] cmdPa, cmdRa;
  logic [DAT_W-1:0] cmdData;
  logic [FRAME_LEN-1:0] shiftReg;
  logic [DAT_W-1:0] rdShift;
  logic             taErr;
  logic             stErr;
  logic [DAT_W-1:0] stData;

  assign cmdWr  = regWrEn && (regAddr == ADDR_W'(OFS_CMD)) && !busy;
  assign launch = cmdWr && regWrData[GO_BIT];
  assign wOp    = regWrData[OP_BIT];
  assign wPa    = regWrData[PA_LSB +: FLD_W];
  assign wRa    = regWrData[RA_LSB +: FLD_W];
  assign wDat   = regWrData[DAT_W-1:0];

  assign isRead  = !cmdOp;
  assign mdioOut = shiftReg[FRAME_LEN-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOp   <= 1'b0;
      cmdPa   <= '0;
      cmdRa   <= '0;
      cmdData <= '0;
    end else if (cmdWr) begin
      cmdOp   <= wOp;
      cmdPa   <= wPa;
      cmdRa   <= wRa;
      cmdData <= wDat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (st.loadFrame) begin
      shiftReg <= {{PRE_LEN{1'b1}}, 2'b01,
                   (wOp ? 2'b01 : 2'b10), wPa, wRa,
                   (wOp ? 2'b10 : 2'b11),
                   (wOp ? wDat : {DAT_W{1'b1}})};
    end else if (st.shiftBit) begin
      shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taErr   <= 1'b0;
      rdShift <= '0;
    end else begin
      if (st.sampleTa)   taErr   <= mdioIn;
      if (st.sampleData) rdShift <= {rdShift[DAT_W-2:0], mdioIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stErr  <= 1'b0;
      stData <= '0;
    end else if (st.finish && !cmdOp) begin
      stErr  <= taErr;
      stData <= rdShift;
    end
  end

  assign statusWord = {stErr, {(REG_W-DAT_W-1){1'b0}}, stData};
  assign cmdWord    = {busy, 4'b0000, cmdOp, cmdPa, cmdRa, cmdData};

  always_comb begin
    if (regAddr == ADDR_W'(OFS_STAT))     regRdData = statusWord;
    else if (regAddr == ADDR_W'(OFS_CMD)) regRdData = cmdWord;
    else                                  regRdData = '0;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrobes_t st;
  logic launch, isRead, busy;
  logic [REG_W-1:0] statusWord, cmdWord;
  logic [26:0] cmdLow;

  assign cmdLow = cmdWord[26:0];

  mdio_ctrl #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .launch(launch), .isRead(isRead),
    .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .st(st)
  );

  mdio_dp #(.ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .st(st),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .launch(launch), .isRead(isRead),
    .statusWord(statusWord), .cmdWord(cmdWord)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CLK_DIV = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        busy,
  input logic [31:0] statusWord,
  input logic [26:0] cmdLow
);
  logic [15:0] halfCnt;
  logic        prevMdc, prevBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt  <= '0;
      prevMdc  <= 1'b0;
      prevBusy <= 1'b0;
    end else begin
      prevMdc  <= mdc;
      prevBusy <= busy;
      if ((mdc != prevMdc) || (busy && !prevBusy)) halfCnt <= 16'd1;
      else if (halfCnt != 16'hFFFF)                halfCnt <= halfCnt + 16'd1;
    end
  end

  a_r8_half_period: assert property (@(posedge clk) disable iff (!rstN)
    (mdc != prevMdc) |-> (halfCnt == 16'(CLK_DIV)));

  a_r8_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> $fell(mdc));

  a_r1_idle_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  a_r2_oe_inside_frame: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  a_r9_status_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusWord) |-> $fell(busy));

  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdLow));
endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .busy(busy), .statusWord(statusWord), .cmdLow(cmdLow)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int CLK_DIV = 4;
  localparam int FRAME_CLKS = 64 * 2 * CLK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  wire  [31:0] regRdData;
  wire  mdc, mdioOut, mdioOe;
  logic phyBit = 1'b1;
  wire  mdioIn = mdioOe ? mdioOut : phyBit;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench PHY model state
  logic [63:0] capBits, oeBits;
  int   riseCnt;
  realtime lastRise;
  bit   periodErr;
  bit   respond;
  logic [15:0] respVal;
  logic [4:0] phyAt;
  bit   phyOn;

  mdio_master #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] phyVal(logic [4:0] pa, logic [4:0] ra);
    return 16'h1357 ^ {ra, pa, 6'h2A};
  endfunction

  function automatic logic [63:0] expLine(bit wr, logic [4:0] pa, logic [4:0] ra,
                                          logic [15:0] d, bit present);
    if (wr) return {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, d};
    return {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 1'b1, !present,
            (present ? phyVal(pa, ra) : 16'hFFFF)};
  endfunction

  always @(posedge mdc) begin
    if (riseCnt > 0 && ($realtime - lastRise) != (2.0 * CLK_DIV * 5.0)) periodErr = 1;
    lastRise = $realtime;
    capBits = {capBits[62:0], mdioIn};
    oeBits  = {oeBits[62:0], mdioOe};
    riseCnt = riseCnt + 1;
  end

  always @(negedge mdc) begin
    if (riseCnt == 46) begin
      respond = (capBits[11:10] == 2'b10) && (capBits[9:5] == phyAt) && phyOn;
      respVal = phyVal(capBits[9:5], capBits[4:0]);
    end
    if (riseCnt == 47)                       phyBit = respond ? 1'b0 : 1'b1;
    else if (riseCnt >= 48 && riseCnt <= 63) phyBit = respond ? respVal[63-riseCnt] : 1'b1;
    else                                     phyBit = 1'b1;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic clearPhy();
    capBits = '0; oeBits = '0; riseCnt = 0; periodErr = 0; respond = 0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      regRead(4'h4, v);
      if (!v[31]) break;
    end
  endtask

  task automatic runTxn(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    logic [31:0] st0, st1, cw;
    bit present;
    present = !wr && phyOn && (pa == phyAt);
    regRead(4'h0, st0);
    clearPhy();
    regWrite(4'h4, {1'b1, 4'b0, wr, pa, ra, d});
    regRead(4'h4, cw);
    chk(cw[31] == 1'b1, "R2 GO busy", cw[31], 1);
    waitIdle();
    regRead(4'h4, cw);
    chk(cw == {1'b0, 4'b0, wr, pa, ra, d}, "R2 GO cleared", cw, {1'b0, 4'b0, wr, pa, ra, d});
    chk(riseCnt == 64, "R2 edge count", riseCnt, 64);
    chk(capBits[63:28] == {32'hFFFF_FFFF, 4'b0101} || capBits[63:28] == {32'hFFFF_FFFF, 4'b0110},
        "R3 preamble start", capBits[63:28], {32'hFFFF_FFFF, 4'b0101});
    chk(periodErr == 0, "R8 mdc period", periodErr, 0);
    regRead(4'h0, st1);
    if (wr) begin
      chk(capBits == expLine(1, pa, ra, d, 0), "R4 write frame", capBits, expLine(1, pa, ra, d, 0));
      chk(oeBits == '1, "R4 oe", oeBits, '1);
      chk(st1 == st0, "R9 status kept", st1, st0);
    end else begin
      chk(capBits == expLine(0, pa, ra, d, present), "R5 read frame", capBits, expLine(0, pa, ra, d, present));
      chk(oeBits == {{46{1'b1}}, 18'b0}, "R5 oe release", oeBits, {{46{1'b1}}, 18'b0});
      chk(st1[15:0] == (present ? phyVal(pa, ra) : 16'hFFFF), "R5 read data", st1[15:0],
          present ? phyVal(pa, ra) : 16'hFFFF);
      chk(st1[31:16] == {!present, 15'b0}, "R6 error flag", st1[31:16], {!present, 15'b0});
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int dummy;
    dummy = $urandom(32'h5EED);
    phyAt = 5'd13; phyOn = 1;
    clearPhy();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(4'h0, v);
    chk(v == 0, "R1 status reset", v, 0);
    regRead(4'h4, v);
    chk(v == 0, "R1 cmd reset", v, 0);
    chk(!mdc && !mdioOe && mdioOut, "R1 pins idle", {mdc, mdioOe, mdioOut}, 3'b001);

    // directed frames
    runTxn(1, 5'd13, 5'd0, 16'h8001);
    runTxn(0, 5'd13, 5'd2, 16'h0);
    runTxn(0, 5'd7, 5'd2, 16'h0);   // absent: error R6
    runTxn(0, 5'd13, 5'd31, 16'h0); // clears error R6
    runTxn(1, 5'd31, 5'd31, 16'hFFFF);
    runTxn(1, 5'd0, 5'd0, 16'h0000);

    // R11 idle write without GO, status write, other offset
    regWrite(4'h4, {1'b0, 4'b0, 1'b1, 5'd3, 5'd4, 16'hBEEF});
    repeat (20) @(negedge clk);
    regRead(4'h4, v);
    chk(v == {1'b0, 4'b0, 1'b1, 5'd3, 5'd4, 16'hBEEF}, "R11 cmd no GO", v,
        {1'b0, 4'b0, 1'b1, 5'd3, 5'd4, 16'hBEEF});
    chk(!mdc && !mdioOe, "R11 no frame", {mdc, mdioOe}, 0);
    regRead(4'h0, v2);
    regWrite(4'h0, 32'hFFFF_FFFF);
    regRead(4'h0, v);
    chk(v == v2, "R11 status write ignored", v, v2);
    regRead(4'h8, v);
    chk(v == 0, "R11 other offset", v, 0);

    // R7 write while busy, and write in the completion cycle
    clearPhy();
    regWrite(4'h4, {1'b1, 4'b0, 1'b1, 5'd9, 5'd1, 16'h1234});
    repeat (100) @(negedge clk);
    regWrite(4'h4, {1'b1, 4'b0, 1'b0, 5'd2, 5'd2, 16'h5555});
    regRead(4'h4, v);
    chk(v == {1'b1, 4'b0, 1'b1, 5'd9, 5'd1, 16'h1234}, "R7 busy write ignored", v,
        {1'b1, 4'b0, 1'b1, 5'd9, 5'd1, 16'h1234});
    waitIdle();
    chk(capBits == expLine(1, 5'd9, 5'd1, 16'h1234, 0), "R7 frame intact", capBits,
        expLine(1, 5'd9, 5'd1, 16'h1234, 0));

    clearPhy();
    regWrite(4'h4, {1'b1, 4'b0, 1'b1, 5'd5, 5'd6, 16'h0F0F});
    repeat (FRAME_CLKS - 2) @(negedge clk);
    regWrite(4'h4, {1'b1, 4'b0, 1'b0, 5'd1, 5'd1, 16'h0});
    regRead(4'h4, v);
    chk(v == {1'b0, 4'b0, 1'b1, 5'd5, 5'd6, 16'h0F0F}, "R7 end-cycle write ignored", v,
        {1'b0, 4'b0, 1'b1, 5'd5, 5'd6, 16'h0F0F});
    repeat (40) @(negedge clk);
    chk(riseCnt == 64, "R7 no extra frame", riseCnt, 64);
    regWrite(4'h4, {1'b0, 4'b0, 1'b0, 5'd1, 5'd1, 16'h0});
    regRead(4'h4, v);
    chk(v == {1'b0, 4'b0, 1'b0, 5'd1, 5'd1, 16'h0}, "R7 next-cycle write taken", v,
        {1'b0, 4'b0, 1'b0, 5'd1, 5'd1, 16'h0});

    // R10 address scan
    for (int a = 0; a < 32; a++) begin
      clearPhy();
      regWrite(4'h4, {1'b1, 4'b0, 1'b0, 5'(a), 5'd2, 16'h0});
      waitIdle();
      regRead(4'h0, v);
      if (a == 13)
        chk(v == {16'h0, phyVal(5'd13, 5'd2)}, "R10 scan hit", v, {16'h0, phyVal(5'd13, 5'd2)});
      else
        chk(v == 32'h8000_FFFF, "R10 scan miss", v, 32'h8000_FFFF);
    end

    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [4:0] pa, ra;
      pa = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 1) pa = phyAt;
      ra = 5'($urandom);
      runTxn(1'($urandom), pa, ra, 16'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule